// File: doc/BRIEF.md
# Option Byte Store and Image

This block holds a small nonvolatile configuration area of eight byte pairs. Each pair keeps a value byte and its bitwise complement. It also holds the register image that actually configures the chip. Software-side logic elsewhere decides when option writes are enabled. This block accepts two kinds of request. An erase request wipes the whole area. A program request writes one value byte into one pair, and the hardware generates the complement byte itself.

The image is copied from the stored bytes only while reset is held, and then it stays frozen. A change to storage therefore takes effect only after the next reset. During the copy, every pair is checked for a valid complement. The image then decodes the pairs into outputs:

- the read-protect state, which is open only when the protection byte equals 8'hA5;
- a user byte and a data half-word;
- 32 write-protect region bits.

A program request that would move the protection byte from a protecting value to the open value 8'hA5 cannot go straight to storage. It first raises a request to an external main-array erase engine. The byte is written only after that engine reports completion.

A separate cold-start input models first power-up. It loads the factory contents into storage, and a normal reset never touches storage.

Top module: `opt_cfg_store`

## Requirements
- R1: After a cold start followed by a reset, storage holds the factory image. The outputs show that image: rdp_on=0, user_cfg=8'hFF, data_cfg=16'hFFFF, wrp_open=32'hFFFF_FFFF. The flags opt_err, wen_err, busy, op_done and me_req are all 0.
- R2: A program request to pair index h (0..7) with byte v writes v to byte offset 2h and ~v to byte offset 2h+1. Byte i of storage appears on nv_view[8i+7:8i]. No other byte changes.
- R3: An erase request sets all 16 stored bytes to 8'hFF.
- R4: A request made while opt_wen=0 and the block is idle changes no stored byte and never raises busy. It sets wen_err, which stays at 1 until the next reset.
- R5: The image outputs (rdp_on, user_cfg, data_cfg, wrp_open, opt_err) change only while rst is 1. A normal reset leaves storage unchanged.
- R6: rdp_on is 0 only when the image protection byte (pair 0, offset 0) equals 8'hA5. It is 1 for any other value.
- R7: The user byte comes from pair 1 (offset 2). data_cfg is {pair 3, pair 2} (offsets 6 and 4). wrp_open[8k+j] is bit j of pair 4+k (offset 8+2k), and 1 means writable.
- R8: At image load, a pair with value/complement is taken as valid, and so is an erased pair 8'hFF/8'hFF. Any other pair sets opt_err and loads a fallback: 8'h00 for the protection pair and for the write-protect pairs, 8'hFF for the user and data pairs.
- R9: Programming 8'hA5 into pair 0 while the stored protection byte is not 8'hA5 raises me_req. me_req stays high until me_done. Storage is unchanged until then, and the write finishes OP_CYCLES cycles after me_done.
- R10: An accepted request keeps busy high for exactly OP_CYCLES cycles when no main-array erase is needed. op_done is a one-cycle pulse in the first idle cycle, with storage already updated. Requests made while busy are ignored.
- R11: Programming pair 0 with a value other than 8'hA5, or when the stored protection byte is already 8'hA5, never raises me_req.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; reloads the image |
| cold_rst | input | 1 | Cold start: loads factory contents into storage |
| opt_wen | input | 1 | Option write enable |
| req_valid | input | 1 | Request strobe |
| req_erase | input | 1 | 1 = erase the whole area, 0 = program one pair |
| req_hw | input | 3 | Pair index for a program request |
| req_lo | input | 8 | Value byte for a program request |
| me_done | input | 1 | Main-array erase finished |
| me_req | output | 1 | Main-array erase request |
| busy | output | 1 | Operation in progress |
| op_done | output | 1 | One-cycle completion pulse |
| wen_err | output | 1 | Sticky: request refused because writes were disabled |
| opt_err | output | 1 | Image load found a corrupt pair |
| rdp_on | output | 1 | Read protection active |
| user_cfg | output | 8 | User configuration byte from the image |
| data_cfg | output | 16 | Two free data bytes from the image |
| wrp_open | output | 32 | Write-protect region bits, 1 = writable |
| nv_view | output | 128 | Current stored bytes, byte i at bits 8i+7:8i |

## Verification
The main function is tried with four patterns:

- an erase from factory contents, which separates a whole-area wipe from a single-pair write;
- programs to the user, data and write-protect pairs with asymmetric bytes, which show that each complement lands at the odd offset next to its own value and that no neighbour is disturbed;
- programs of the protection pair, once with a non-open value and once with 8'hA5 over a protecting value and over an already-open one, which tell apart the two paths that skip the main-array erase from the one that must wait for it;
- a second instance started from a deliberately corrupted factory image, paired with erased pairs in the main instance, which separates the erased-but-valid case from the mismatch that forces fallback values.

Image stability is checked by comparing the outputs before and after reset around each storage change.

// File: rtl/opt_cfg_pkg.sv
package opt_cfg_pkg;
    localparam int unsigned PAIRS     = 8;
    localparam int unsigned BYTES     = 2 * PAIRS;
    localparam int unsigned NV_BITS   = 8 * BYTES;
    localparam int unsigned VAL_BITS  = 8 * PAIRS;
    localparam int unsigned PW        = $clog2(PAIRS);
    localparam int unsigned WRP_BASE  = 4;
    localparam int unsigned WRP_BITS  = 8 * (PAIRS - WRP_BASE);
    localparam logic [7:0]  RDP_OPEN  = 8'hA5;
    localparam logic [7:0]  BLANK     = 8'hFF;

    typedef enum logic {OP_ERASE = 1'b0, OP_PROG = 1'b1} op_e;
    typedef enum logic [1:0] {S_IDLE, S_MERASE, S_WORK} seq_e;

    typedef struct packed {
        op_e           kind;
        logic [PW-1:0] pair;
        logic [7:0]    lo;
    } op_t;

    // protective value used when a pair fails its complement check
    function automatic logic [7:0] fallback(input int p);
        if (p == 0 || p >= int'(WRP_BASE)) return 8'h00;
        return 8'hFF;
    endfunction

    // build a well-formed stored image from the eight value bytes
    function automatic logic [NV_BITS-1:0] pack_image(input logic [7:0] rdp,
                                                     input logic [7:0] user,
                                                     input logic [15:0] data,
                                                     input logic [31:0] wrp);
        logic [VAL_BITS-1:0] v;
        logic [NV_BITS-1:0]  r;
        v = {wrp, data, user, rdp};
        r = '0;
        for (int p = 0; p < int'(PAIRS); p++) begin
            r[16*p +: 8]     = v[8*p +: 8];
            r[16*p + 8 +: 8] = ~v[8*p +: 8];
        end
        return r;
    endfunction
endpackage

// File: rtl/opt_nv_array.sv
module opt_nv_array
    import opt_cfg_pkg::*;
#(
    parameter logic [NV_BITS-1:0] FACTORY = '1
) (
    input  logic               clk,
    input  logic               cold_rst,
    input  logic               wr_erase,
    input  logic               wr_prog,
    input  logic [PW-1:0]      wr_pair,
    input  logic [7:0]         wr_lo,
    output logic [NV_BITS-1:0] bytes_o
);
    for (genvar p = 0; p < int'(PAIRS); p++) begin : g_pair
        logic [7:0] val_q;
        logic [7:0] cmp_q;

        always_ff @(posedge clk) begin
            if (cold_rst) begin
                val_q <= FACTORY[16*p +: 8];
                cmp_q <= FACTORY[16*p + 8 +: 8];
            end else if (wr_erase) begin
                val_q <= BLANK;
                cmp_q <= BLANK;
            end else if (wr_prog && wr_pair == PW'(p)) begin
                val_q <= wr_lo;
                cmp_q <= ~wr_lo;
            end
        end

        assign bytes_o[16*p +: 16] = {cmp_q, val_q};
    end
endmodule

// File: rtl/opt_image.sv
module opt_image
    import opt_cfg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NV_BITS-1:0]  nv_i,
    output logic [VAL_BITS-1:0] val_o,
    output logic                err_o
);
    logic [VAL_BITS-1:0] nxt_val;
    logic [PAIRS-1:0]    bad;
    logic [VAL_BITS-1:0] val_q;
    logic                err_q;

    always_comb begin
        nxt_val = '0;
        bad     = '0;
        for (int p = 0; p < int'(PAIRS); p++) begin
            logic [7:0] lo;
            logic [7:0] hi;
            lo = nv_i[16*p +: 8];
            hi = nv_i[16*p + 8 +: 8];
            if (hi == ~lo || (lo == BLANK && hi == BLANK)) begin
                nxt_val[8*p +: 8] = lo;
            end else begin
                nxt_val[8*p +: 8] = fallback(p);
                bad[p]            = 1'b1;
            end
        end
    end

    // image captured only while reset is held
    always_ff @(posedge clk) begin
        if (rst) begin
            val_q <= nxt_val;
            err_q <= |bad;
        end
    end

    assign val_o = val_q;
    assign err_o = err_q;
endmodule

// File: rtl/opt_seq.sv
module opt_seq
    import opt_cfg_pkg::*;
#(
    parameter int unsigned OP_CYCLES = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  op_e           req_kind,
    input  logic [PW-1:0] req_pair,
    input  logic [7:0]    req_lo,
    input  logic          wen,
    input  logic [7:0]    stored_rdp,
    input  logic          me_done,
    output logic          me_req,
    output logic          busy,
    output logic          done,
    output logic          wen_err,
    output logic          wr_erase,
    output logic          wr_prog,
    output logic [PW-1:0] wr_pair,
    output logic [7:0]    wr_lo
);
    localparam int unsigned CW = (OP_CYCLES > 1) ? $clog2(OP_CYCLES) : 1;

    seq_e          state;
    logic [CW-1:0] cnt;
    op_t           op_q;
    logic          done_q;
    logic          werr_q;
    logic          accept;
    logic          lifts_rdp;
    logic          commit;

    assign accept    = req_valid && state == S_IDLE;
    assign lifts_rdp = req_kind == OP_PROG && req_pair == '0 &&
                       req_lo == RDP_OPEN && stored_rdp != RDP_OPEN;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            cnt    <= '0;
            op_q   <= '0;
            done_q <= 1'b0;
            werr_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (accept) begin
                        if (!wen) begin
                            werr_q <= 1'b1;
                        end else begin
                            op_q  <= '{kind: req_kind, pair: req_pair, lo: req_lo};
                            cnt   <= CW'(OP_CYCLES - 1);
                            state <= lifts_rdp ? S_MERASE : S_WORK;
                        end
                    end
                end
                S_MERASE: begin
                    if (me_done) state <= S_WORK;
                end
                S_WORK: begin
                    if (cnt == '0) begin
                        state  <= S_IDLE;
                        done_q <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign commit   = state == S_WORK && cnt == '0;
    assign wr_erase = commit && op_q.kind == OP_ERASE;
    assign wr_prog  = commit && op_q.kind == OP_PROG;
    assign wr_pair  = op_q.pair;
    assign wr_lo    = op_q.lo;
    assign me_req   = state == S_MERASE;
    assign busy     = state != S_IDLE;
    assign done     = done_q;
    assign wen_err  = werr_q;
endmodule

// File: rtl/opt_cfg_store.sv
module opt_cfg_store
    import opt_cfg_pkg::*;
#(
    parameter int unsigned        OP_CYCLES = 4,
    parameter logic [NV_BITS-1:0] FACTORY   = pack_image(8'hA5, 8'hFF, 16'hFFFF, 32'hFFFF_FFFF)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cold_rst,
    input  logic                opt_wen,
    input  logic                req_valid,
    input  logic                req_erase,
    input  logic [PW-1:0]       req_hw,
    input  logic [7:0]          req_lo,
    input  logic                me_done,
    output logic                me_req,
    output logic                busy,
    output logic                op_done,
    output logic                wen_err,
    output logic                opt_err,
    output logic                rdp_on,
    output logic [7:0]          user_cfg,
    output logic [15:0]         data_cfg,
    output logic [WRP_BITS-1:0] wrp_open,
    output logic [NV_BITS-1:0]  nv_view
);
    logic                wr_erase;
    logic                wr_prog;
    logic [PW-1:0]       wr_pair;
    logic [7:0]          wr_lo;
    logic [VAL_BITS-1:0] img_val;
    op_e                 req_kind;

    assign req_kind = req_erase ? OP_ERASE : OP_PROG;

    opt_seq #(.OP_CYCLES(OP_CYCLES)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_kind   (req_kind),
        .req_pair   (req_hw),
        .req_lo     (req_lo),
        .wen        (opt_wen),
        .stored_rdp (nv_view[7:0]),
        .me_done    (me_done),
        .me_req     (me_req),
        .busy       (busy),
        .done       (op_done),
        .wen_err    (wen_err),
        .wr_erase   (wr_erase),
        .wr_prog    (wr_prog),
        .wr_pair    (wr_pair),
        .wr_lo      (wr_lo)
    );

    opt_nv_array #(.FACTORY(FACTORY)) u_nv (
        .clk      (clk),
        .cold_rst (cold_rst),
        .wr_erase (wr_erase),
        .wr_prog  (wr_prog),
        .wr_pair  (wr_pair),
        .wr_lo    (wr_lo),
        .bytes_o  (nv_view)
    );

    opt_image u_img (
        .clk   (clk),
        .rst   (rst),
        .nv_i  (nv_view),
        .val_o (img_val),
        .err_o (opt_err)
    );

    assign rdp_on   = img_val[7:0] != RDP_OPEN;
    assign user_cfg = img_val[15:8];
    assign data_cfg = img_val[31:16];
    assign wrp_open = img_val[VAL_BITS-1 -: WRP_BITS];
endmodule

// File: rtl/opt_cfg_chk.sv
module opt_cfg_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        opt_wen,
    input logic        busy,
    input logic        me_req,
    input logic        me_done,
    input logic        op_done,
    input logic        wen_err,
    input logic        opt_err,
    input logic        rdp_on,
    input logic [7:0]  user_cfg,
    input logic [15:0] data_cfg,
    input logic [31:0] wrp_open
);
    // R9
    merase_busy_chk: assert property (@(posedge clk) disable iff (rst)
        me_req |-> busy);

    // R9
    merase_hold_chk: assert property (@(posedge clk) disable iff (rst)
        me_req && !me_done |=> me_req);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        op_done |=> !op_done);

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        op_done |-> !busy);

    // R4
    wen_block_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && !opt_wen && !busy |=> wen_err && !busy);

    // R4
    wen_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        wen_err |=> wen_err);

    // R5
    img_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(rdp_on) && $stable(user_cfg) && $stable(data_cfg)
                        && $stable(wrp_open) && $stable(opt_err));
endmodule

bind opt_cfg_store opt_cfg_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .opt_wen   (opt_wen),
    .busy      (busy),
    .me_req    (me_req),
    .me_done   (me_done),
    .op_done   (op_done),
    .wen_err   (wen_err),
    .opt_err   (opt_err),
    .rdp_on    (rdp_on),
    .user_cfg  (user_cfg),
    .data_cfg  (data_cfg),
    .wrp_open  (wrp_open)
);

// File: tb/opt_cfg_store_tb.sv
module opt_cfg_store_tb;
    import opt_cfg_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int OPC        = 4;
    localparam int ME_WAIT    = 5;
    localparam logic [127:0] FACT = pack_image(8'hA5, 8'hFF, 16'hFFFF, 32'hFFFF_FFFF);
    // user pair with a broken complement, WRP0 pair with equal bytes
    localparam logic [127:0] BAD_IMG =
        (pack_image(8'hA5, 8'h12, 16'hFFFF, 32'hFFFF_FF0F)
         & ~(128'hFF << 24) & ~(128'hFF << 72)) | (128'h0F << 72);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cold_rst = 1'b1;
    logic        opt_wen = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_erase = 1'b0;
    logic [2:0]  req_hw = '0;
    logic [7:0]  req_lo = '0;
    logic        me_done = 1'b0;
    logic        me_req, busy, op_done, wen_err, opt_err, rdp_on;
    logic [7:0]  user_cfg;
    logic [15:0] data_cfg;
    logic [31:0] wrp_open;
    logic [127:0] nv_view;

    logic        b_me_req, b_busy, b_done, b_wen_err, b_opt_err, b_rdp_on;
    logic [7:0]  b_user;
    logic [15:0] b_data;
    logic [31:0] b_wrp;
    logic [127:0] b_nv;

    always #(CLK_PERIOD/2) clk = ~clk;

    opt_cfg_store #(.OP_CYCLES(OPC), .FACTORY(FACT)) u_dut (
        .clk(clk), .rst(rst), .cold_rst(cold_rst), .opt_wen(opt_wen),
        .req_valid(req_valid), .req_erase(req_erase), .req_hw(req_hw), .req_lo(req_lo),
        .me_done(me_done), .me_req(me_req), .busy(busy), .op_done(op_done),
        .wen_err(wen_err), .opt_err(opt_err), .rdp_on(rdp_on), .user_cfg(user_cfg),
        .data_cfg(data_cfg), .wrp_open(wrp_open), .nv_view(nv_view)
    );

    opt_cfg_store #(.OP_CYCLES(OPC), .FACTORY(BAD_IMG)) u_bad (
        .clk(clk), .rst(rst), .cold_rst(cold_rst), .opt_wen(1'b0),
        .req_valid(1'b0), .req_erase(1'b0), .req_hw(3'd0), .req_lo(8'd0),
        .me_done(1'b0), .me_req(b_me_req), .busy(b_busy), .op_done(b_done),
        .wen_err(b_wen_err), .opt_err(b_opt_err), .rdp_on(b_rdp_on), .user_cfg(b_user),
        .data_cfg(b_data), .wrp_open(b_wrp), .nv_view(b_nv)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int me_seen = 0;
    bit finished = 1'b0;
    logic [7:0]   mdl [16];
    logic [127:0] exp_q [$];

    task automatic check(input bit ok, input string tag, input logic [127:0] act,
                         input logic [127:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] flat();
        logic [127:0] r;
        for (int i = 0; i < 16; i++) r[8*i +: 8] = mdl[i];
        return r;
    endfunction

    function automatic void load_factory();
        for (int i = 0; i < 16; i++) mdl[i] = FACT[8*i +: 8];
    endfunction

    // scoreboard monitor: each completion must match the next expected storage
    always @(negedge clk) begin
        if (!rst && op_done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10 completion without request", 128'd1, 128'd0);
            end else begin
                logic [127:0] e;
                e = exp_q.pop_front();
                check(nv_view == e, "R2/R3 storage at completion", nv_view, e);
            end
        end
    end

    // main-array erase engine model
    always begin
        @(negedge clk);
        if (me_req && !me_done) begin
            me_seen++;
            repeat (ME_WAIT - 1) @(negedge clk);
            me_done = 1'b1;
            @(negedge clk);
            me_done = 1'b0;
        end
    end

    task automatic do_reset(input bit cold);
        @(negedge clk);
        rst = 1'b1;
        cold_rst = cold;
        @(negedge clk);
        cold_rst = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        if (cold) load_factory();
    endtask

    task automatic do_op(input bit erase, input int hw, input logic [7:0] v,
                         input bit wen, output int bcyc);
        @(negedge clk);
        opt_wen   = wen;
        req_valid = 1'b1;
        req_erase = erase;
        req_hw    = hw[2:0];
        req_lo    = v;
        if (wen) begin
            if (erase) begin
                for (int i = 0; i < 16; i++) mdl[i] = 8'hFF;
            end else begin
                mdl[2*hw]   = v;
                mdl[2*hw+1] = ~v;
            end
            exp_q.push_back(flat());
        end
        @(negedge clk);
        req_valid = 1'b0;
        bcyc = 0;
        while (busy) begin
            bcyc++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
            $finish;
        end
    end

    initial begin
        int bc;
        logic [127:0] pre;
        do_reset(1'b1);

        // R1 reset state
        check(rdp_on == 1'b0 && opt_err == 1'b0 && wen_err == 1'b0, "R1 flags",
              {rdp_on, opt_err, wen_err}, 3'b000);
        check(busy == 1'b0 && op_done == 1'b0 && me_req == 1'b0, "R1 idle",
              {busy, op_done, me_req}, 3'b000);
        check(user_cfg == 8'hFF && data_cfg == 16'hFFFF && wrp_open == 32'hFFFF_FFFF,
              "R1 image", {user_cfg, data_cfg, wrp_open}, {8'hFF, 16'hFFFF, 32'hFFFF_FFFF});
        check(nv_view == FACT, "R1 storage", nv_view, FACT);

        // R8 corrupted pairs fall back
        check(b_opt_err == 1'b1, "R8 mismatch flag", b_opt_err, 1'b1);
        check(b_user == 8'hFF && b_wrp == 32'hFFFF_FF00 && b_rdp_on == 1'b0,
              "R8 fallback values", {b_user, b_wrp, b_rdp_on}, {8'hFF, 32'hFFFF_FF00, 1'b0});

        // R4 request with writes disabled
        pre = nv_view;
        do_op(1'b0, 1, 8'h5A, 1'b0, bc);
        check(nv_view == pre, "R4 storage untouched", nv_view, pre);
        check(wen_err == 1'b1 && bc == 0, "R4 error flag and no busy", {wen_err, bc}, {1'b1, 32'd0});

        // R3 erase, R10 latency
        do_op(1'b1, 0, 8'h00, 1'b1, bc);
        check(nv_view == {16{8'hFF}}, "R3 erased", nv_view, {16{8'hFF}});
        check(bc == OPC, "R10 busy cycles", bc, OPC);

        // R2 program with generated complement
        do_op(1'b0, 1, 8'h5A, 1'b1, bc);
        check(nv_view[23:16] == 8'h5A && nv_view[31:24] == 8'hA5, "R2 pair 1 bytes",
              nv_view[31:16], 16'hA55A);
        check(nv_view[127:32] == {12{8'hFF}} && nv_view[15:0] == 16'hFFFF, "R2 neighbours",
              nv_view, {{12{8'hFF}}, 16'hA55A, 16'hFFFF});
        do_op(1'b0, 4, 8'hF0, 1'b1, bc);
        do_op(1'b0, 7, 8'h7E, 1'b1, bc);
        do_op(1'b0, 2, 8'h34, 1'b1, bc);
        do_op(1'b0, 0, 8'h33, 1'b1, bc);
        check(me_seen == 0, "R11 non-open value", me_seen, 0);
        // R5 image frozen while storage changed
        check(rdp_on == 1'b0 && user_cfg == 8'hFF && wrp_open == 32'hFFFF_FFFF, "R5 frozen",
              {rdp_on, user_cfg, wrp_open}, {1'b0, 8'hFF, 32'hFFFF_FFFF});

        pre = nv_view;
        do_reset(1'b0);
        check(nv_view == pre, "R5 storage survives reset", nv_view, pre);
        check(rdp_on == 1'b1, "R6 protected by 33", rdp_on, 1'b1);
        check(wrp_open == 32'h7EFF_FFF0, "R7 region bits", wrp_open, 32'h7EFF_FFF0);
        check(user_cfg == 8'h5A && data_cfg == 16'hFF34, "R7 user and data",
              {user_cfg, data_cfg}, {8'h5A, 16'hFF34});
        check(opt_err == 1'b0 && wen_err == 1'b0, "R8 erased pair valid", {opt_err, wen_err}, 2'b00);

        // R9 lifting read protection waits for the main-array erase
        pre = nv_view;
        @(negedge clk);
        opt_wen = 1'b1; req_valid = 1'b1; req_erase = 1'b0; req_hw = 3'd0; req_lo = 8'hA5;
        mdl[0] = 8'hA5; mdl[1] = 8'h5A;
        exp_q.push_back(flat());
        @(negedge clk);
        req_valid = 1'b0;
        check(me_req == 1'b1 && busy == 1'b1, "R9 erase requested", {me_req, busy}, 2'b11);
        @(negedge clk);
        check(nv_view == pre, "R9 storage held", nv_view, pre);
        while (busy) @(negedge clk);
        check(me_seen == 1 && nv_view[15:0] == 16'h5AA5, "R9 written after erase",
              {me_seen, nv_view[15:0]}, {32'd1, 16'h5AA5});
        check(rdp_on == 1'b1, "R5 still protected before reset", rdp_on, 1'b1);
        do_reset(1'b0);
        check(rdp_on == 1'b0, "R6 open after reset", rdp_on, 1'b0);

        // R11 already open
        do_op(1'b0, 0, 8'hA5, 1'b1, bc);
        check(me_seen == 1 && bc == OPC, "R11 already open", {me_seen, bc}, {32'd1, OPC});

        // R10 request while busy is ignored
        @(negedge clk);
        opt_wen = 1'b1; req_valid = 1'b1; req_erase = 1'b0; req_hw = 3'd2; req_lo = 8'h11;
        mdl[4] = 8'h11; mdl[5] = 8'hEE;
        exp_q.push_back(flat());
        @(negedge clk);
        req_hw = 3'd3; req_lo = 8'h22;
        @(negedge clk);
        req_valid = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
        check(nv_view == flat(), "R10 busy request ignored", nv_view, flat());

        // R4 erase refused
        pre = nv_view;
        do_op(1'b1, 0, 8'h00, 1'b0, bc);
        check(nv_view == pre && wen_err == 1'b1, "R4 erase refused", nv_view, pre);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R10 all completions seen", exp_q.size(), 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule